// File: doc/BRIEF.md
# Bandwidth-Driven Memory Temperature Estimator

The block turns a free-running count of memory accesses into a temperature proxy for DRAM. On every update strobe it takes the number of accesses since the previous strobe. It lets the stored temperature state decay by a programmable fraction and adds the access count scaled by a programmable gain. The integer part of that state, plus a programmable offset, is the estimate.

A 32-bit configuration word holds the gain, the decay factor, the offset and three flags that switch off individual temperature sources. Software may write the word at any time. The running estimator only uses the copy taken when the capture strobe fires, which is asserted during one reset phase. The estimate is combined with a sideband temperature and an external hot flag into one selected temperature. Only the sources whose disable flags are clear take part.

Top module: `mem_bw_thermal_est`

## Requirements
- R1: After reset `cfg_rdata` reads 0x438C_8324. The field layout is: gain in bits 31:22, decay in bits 21:12, offset in bits 10:4, external-flag disable in bit 2, estimate disable in bit 1 and sideband disable in bit 0. The working copy starts with the same field values, so the estimate starts at 50.
- R2: Bits 11 and 3 of `cfg_rdata` always read zero. A write with `cfg_we` stores every other bit of `cfg_wdata`, and the new value is visible on the next cycle.
- R3: The fields that drive the estimator and the selector are loaded from the configuration word only on a cycle with `cfg_capture` high. A write without a capture changes neither the estimate nor the selection.
- R4: A capture clears the temperature state to zero and loads `acc_count` as the baseline for the next delta.
- R5: On each cycle with `tick` high, the state is updated exactly once and the baseline becomes `acc_count`. The result appears on the outputs after that clock edge. Without `tick` or `cfg_capture`, the estimate holds.
- R6: The state T has 44 fractional bits and 8 integer bits. One update sets T to T − floor(decay·T_raw / 2^25) + gain·delta, where delta is taken in units of 2^-44 degrees and the decay term is computed from the previous state.
- R7: delta is `acc_count` minus the baseline, modulo 2^40, so a counter wrap between strobes gives the correct positive delta.
- R8: The state saturates at its largest value and at zero, and never wraps.
- R9: `est_temp` is the integer part of T plus the 7-bit offset, saturated at 255.
- R10: `sel_temp` is the maximum of the temperatures that are enabled: the estimate unless bit 1 is set, and `sb_temp` unless bit 0 is set.
- R11: When bit 2 is clear and `ext_hot` is high, `sel_hot` is 1 and `sel_temp` is 255. When bit 2 is set, `ext_hot` is ignored.
- R12: When all three sources are disabled, `sel_valid`, `sel_hot` and `sel_temp` are all zero. Otherwise `sel_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored configuration word |
| cfg_capture | input | 1 | Reset-phase strobe: load working copy, clear state |
| tick | input | 1 | Periodic update strobe (nominally 1 ms) |
| acc_count | input | 40 | Free-running memory access counter |
| ext_hot | input | 1 | External sensor over-temperature flag |
| sb_temp | input | 8 | Temperature supplied over the sideband |
| est_temp | output | 8 | Bandwidth-based estimate |
| sel_temp | output | 8 | Selected temperature |
| sel_hot | output | 1 | External hot indication in force |
| sel_valid | output | 1 | At least one source enabled |

## Verification
The checker watches four rules on every cycle. Reserved bits read zero and writes land in the word one cycle later. The estimate is stable between strobes and never drops below the captured offset. A hot indication always pairs with a full-scale valid temperature, and an invalid selection is all zero. Only the bench scenarios can show the arithmetic itself. That covers exact fixed-point accumulation, the decay term flipping an integer-valued state down by one degree, the modular delta across a counter wrap, and saturation instead of wrap after many large deltas. The same holds for the one-time capture semantics and the source combinations.

// File: rtl/mte_pkg.sv
package mte_pkg;

    localparam int CFG_W   = 32;
    localparam int GAIN_W  = 10;
    localparam int DECAY_W = 10;
    localparam int OFF_W   = 7;

    localparam logic [CFG_W-1:0] CFG_RESET = 32'h438C_8324;
    // bits 11 and 3 are reserved and stay zero
    localparam logic [CFG_W-1:0] CFG_WMASK = 32'hFFFF_F7F7;

    typedef struct packed {
        logic [GAIN_W-1:0]  gain;
        logic [DECAY_W-1:0] decay;
        logic [OFF_W-1:0]   offset;
        logic               dis_ext;
        logic               dis_bw;
        logic               dis_sb;
    } mte_cfg_t;

    function automatic mte_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        mte_cfg_t f;
        f.gain    = w[31:22];
        f.decay   = w[21:12];
        f.offset  = w[10:4];
        f.dis_ext = w[2];
        f.dis_bw  = w[1];
        f.dis_sb  = w[0];
        return f;
    endfunction

endpackage

// File: rtl/mte_cfg_reg.sv
module mte_cfg_reg
    import mte_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             capture,
    output logic [CFG_W-1:0] rdata,
    output mte_cfg_t         work
);

    typedef struct packed {
        logic [CFG_W-1:0] word;
        mte_cfg_t         work;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.word = wdata & CFG_WMASK;
        end
        if (capture) begin
            st_d.work = unpack_cfg(st_q.word);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word <= CFG_RESET;
            st_q.work <= unpack_cfg(CFG_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.word;
    assign work  = st_q.work;

endmodule

// File: rtl/mte_integrator.sv
module mte_integrator
    import mte_pkg::*;
#(
    parameter int ACC_W       = 40,
    parameter int INT_W       = 8,
    parameter int FRAC_W      = 44,
    parameter int DECAY_SHIFT = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic               tick,
    input  logic [ACC_W-1:0]   acc_count,
    input  logic [GAIN_W-1:0]  gain,
    input  logic [DECAY_W-1:0] decay,
    output logic [INT_W-1:0]   t_int
);

    localparam int T_W    = INT_W + FRAC_W;
    localparam int GP_W   = GAIN_W + ACC_W;
    localparam int DP_W   = DECAY_W + T_W;
    localparam int WIDE_W = ((T_W > GP_W) ? T_W : GP_W) + 2;

    typedef struct packed {
        logic [T_W-1:0]   t;
        logic [ACC_W-1:0] base;
    } int_state_t;

    int_state_t        st_d, st_q;
    logic [ACC_W-1:0]  delta;
    logic [GP_W-1:0]   gain_prod;
    logic [DP_W-1:0]   dec_prod;
    logic [WIDE_W-1:0] sum;

    always_comb begin
        st_d      = st_q;
        delta     = acc_count - st_q.base;
        gain_prod = GP_W'(gain) * GP_W'(delta);
        dec_prod  = DP_W'(decay) * DP_W'(st_q.t);
        sum       = WIDE_W'(st_q.t) - WIDE_W'(dec_prod >> DECAY_SHIFT)
                  + WIDE_W'(gain_prod);
        if (capture) begin
            st_d.t    = '0;
            st_d.base = acc_count;
        end else if (tick) begin
            st_d.base = acc_count;
            if (sum[WIDE_W-1]) begin
                st_d.t = '0;
            end else if (|sum[WIDE_W-2:T_W]) begin
                st_d.t = '1;
            end else begin
                st_d.t = sum[T_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign t_int = st_q.t[T_W-1:FRAC_W];

endmodule

// File: rtl/mte_select.sv
module mte_select #(
    parameter int TEMP_W = 8
) (
    input  logic [TEMP_W-1:0] est,
    input  logic [TEMP_W-1:0] sb_temp,
    input  logic              ext_hot,
    input  logic              dis_ext,
    input  logic              dis_bw,
    input  logic              dis_sb,
    output logic [TEMP_W-1:0] sel_temp,
    output logic              sel_hot,
    output logic              sel_valid
);

    localparam int N_SRC = 2;

    logic [TEMP_W-1:0] src_val [N_SRC];
    logic [N_SRC-1:0]  src_en;
    logic [TEMP_W-1:0] best;

    assign src_val[0] = est;
    assign src_val[1] = sb_temp;
    assign src_en     = {~dis_sb, ~dis_bw};

    always_comb begin
        best = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (src_en[i] && (src_val[i] > best)) begin
                best = src_val[i];
            end
        end
        sel_hot   = ~dis_ext & ext_hot;
        sel_valid = (|src_en) | ~dis_ext;
        sel_temp  = sel_hot ? '1 : best;
    end

endmodule

// File: rtl/mem_bw_thermal_est.sv
module mem_bw_thermal_est
    import mte_pkg::*;
#(
    parameter int ACC_W       = 40,
    parameter int INT_W       = 8,
    parameter int FRAC_W      = 44,
    parameter int DECAY_SHIFT = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             cfg_capture,
    input  logic             tick,
    input  logic [ACC_W-1:0] acc_count,
    input  logic             ext_hot,
    input  logic [INT_W-1:0] sb_temp,
    output logic [INT_W-1:0] est_temp,
    output logic [INT_W-1:0] sel_temp,
    output logic             sel_hot,
    output logic             sel_valid
);

    mte_cfg_t         work;
    logic [INT_W-1:0] t_int;
    logic [OFF_W-1:0] off_w;
    logic [INT_W:0]   est_sum;

    mte_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .capture (cfg_capture),
        .rdata   (cfg_rdata),
        .work    (work)
    );

    mte_integrator #(
        .ACC_W       (ACC_W),
        .INT_W       (INT_W),
        .FRAC_W      (FRAC_W),
        .DECAY_SHIFT (DECAY_SHIFT)
    ) u_int (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (cfg_capture),
        .tick      (tick),
        .acc_count (acc_count),
        .gain      (work.gain),
        .decay     (work.decay),
        .t_int     (t_int)
    );

    assign off_w   = work.offset;
    assign est_sum = (INT_W+1)'(t_int) + (INT_W+1)'(off_w);
    assign est_temp = est_sum[INT_W] ? '1 : est_sum[INT_W-1:0];

    mte_select #(
        .TEMP_W (INT_W)
    ) u_sel (
        .est       (est_temp),
        .sb_temp   (sb_temp),
        .ext_hot   (ext_hot),
        .dis_ext   (work.dis_ext),
        .dis_bw    (work.dis_bw),
        .dis_sb    (work.dis_sb),
        .sel_temp  (sel_temp),
        .sel_hot   (sel_hot),
        .sel_valid (sel_valid)
    );

endmodule

// File: rtl/mte_checker.sv
module mte_checker
    import mte_pkg::*;
#(
    parameter int INT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             cfg_capture,
    input logic             tick,
    input logic [INT_W-1:0] est_temp,
    input logic [INT_W-1:0] sel_temp,
    input logic             sel_hot,
    input logic             sel_valid,
    input logic [OFF_W-1:0] off_q
);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[11] == 1'b0) && (cfg_rdata[3] == 1'b0));

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & CFG_WMASK)));

    a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cfg_capture) |=> $stable(est_temp));

    a_r9_offset_floor: assert property (@(posedge clk) disable iff (!rst_n)
        est_temp >= INT_W'(off_q));

    a_r11_hot_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hot |-> (sel_valid && (sel_temp == '1)));

    a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> ((sel_temp == '0) && !sel_hot));

endmodule

bind mem_bw_thermal_est mte_checker #(.INT_W(INT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .cfg_capture (cfg_capture),
    .tick        (tick),
    .est_temp    (est_temp),
    .sel_temp    (sel_temp),
    .sel_hot     (sel_hot),
    .sel_valid   (sel_valid),
    .off_q       (off_w)
);

// File: tb/mem_bw_thermal_est_test.sv
module mem_bw_thermal_est_test;

    localparam int CLK_PERIOD = 10;
    localparam int ACC_W      = 40;
    localparam int UNIT_SH    = 35;   // 2^35 accesses x gain 512 = 1.0 degree
    localparam int N_VEC      = 5;
    // {acc_count in units of 2^35, expected estimate}
    localparam logic [12:0] VEC [N_VEC] = '{
        {5'd10, 8'd8},
        {5'd17, 8'd15},
        {5'd5,  8'd35},   // wraps: delta 20 units
        {5'd9,  8'd39},
        {5'd9,  8'd39}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [31:0]      cfg_wdata = '0;
    logic [31:0]      cfg_rdata;
    logic             cfg_capture = 1'b0;
    logic             tick = 1'b0;
    logic [ACC_W-1:0] acc_count = '0;
    logic             ext_hot = 1'b0;
    logic [7:0]       sb_temp = '0;
    logic [7:0]       est_temp, sel_temp;
    logic             sel_hot, sel_valid;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_bw_thermal_est uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .cfg_capture (cfg_capture),
        .tick        (tick),
        .acc_count   (acc_count),
        .ext_hot     (ext_hot),
        .sb_temp     (sb_temp),
        .est_temp    (est_temp),
        .sel_temp    (sel_temp),
        .sel_hot     (sel_hot),
        .sel_valid   (sel_valid)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog act=%0d exp=finish", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic capture();
        cfg_capture = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_capture = 1'b0;
    endtask

    task automatic do_tick(input logic [ACC_W-1:0] a);
        acc_count = a;
        tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R1 reset word", cfg_rdata, 32'h438C_8324);
        chk("R1 reset estimate", 32'(est_temp), 32'd50);
        chk("R10 reset select", {22'd0, sel_valid, sel_hot, sel_temp}, {22'd0, 1'b1, 1'b0, 8'd50});
        ext_hot = 1'b1;
        #1;
        chk("R11 flag ignored when disabled", {23'd0, sel_hot, sel_temp}, {23'd0, 1'b0, 8'd50});
        ext_hot = 1'b0;

        // reserved bits, write without capture
        write_cfg(32'hFFFF_FFFF);
        chk("R2 reserved read zero", cfg_rdata, 32'hFFFF_F7F7);
        chk("R3 write alone keeps estimate", 32'(est_temp), 32'd50);
        chk("R3 write alone keeps selection", {31'd0, sel_valid}, 32'd1);
        do_tick('0);
        chk("R3 tick uses captured offset", 32'(est_temp), 32'd50);

        // gain 512, decay 0, offset 5, all sources on; baseline 7 units
        write_cfg(32'h8000_0050);
        acc_count = ACC_W'(7) << UNIT_SH;
        capture();
        chk("R4 capture clears state", 32'(est_temp), 32'd5);
        do_tick(ACC_W'(7) << UNIT_SH);
        chk("R4 baseline reloaded", 32'(est_temp), 32'd5);

        for (int i = 0; i < N_VEC; i++) begin
            do_tick(ACC_W'(VEC[i][12:8]) << UNIT_SH);
            chk("R6 R7 accumulate", 32'(est_temp), 32'(VEC[i][7:0]));
            chk("R10 max with idle sideband", 32'(sel_temp), 32'(VEC[i][7:0]));
        end

        // no tick: estimate holds even though counter moves
        acc_count = ACC_W'(20) << UNIT_SH;
        repeat (3) @(negedge clk);
        chk("R5 hold without tick", 32'(est_temp), 32'd39);
        sb_temp = 8'd60;
        #1;
        chk("R10 sideband larger", 32'(sel_temp), 32'd60);
        sb_temp = 8'd20;
        #1;
        chk("R10 estimate larger", 32'(sel_temp), 32'd39);
        sb_temp = 8'd0;

        // decay: gain 512, decay 1023, offset 0
        write_cfg(32'h803F_F000);
        acc_count = '0;
        capture();
        do_tick(ACC_W'(5) << UNIT_SH);
        chk("R6 exact integer gain", 32'(est_temp), 32'd5);
        do_tick(ACC_W'(5) << UNIT_SH);
        chk("R6 decay drops below integer", 32'(est_temp), 32'd4);

        // saturation: gain 1023, decay 0, offset 3, delta 2^39 per tick
        write_cfg(32'hFFC0_0030);
        acc_count = '0;
        capture();
        for (int k = 1; k <= 10; k++) begin
            do_tick((k % 2 == 1) ? (ACC_W'(1) << 39) : '0);
        end
        chk("R8 R9 saturate not wrap", 32'(est_temp), 32'd255);
        do_tick('0);
        chk("R8 stays saturated", 32'(est_temp), 32'd255);

        // only external flag enabled, offset 40, gain 0
        write_cfg(32'h0000_0283);
        capture();
        chk("R11 flag low", {22'd0, sel_valid, sel_hot, sel_temp}, {22'd0, 1'b1, 1'b0, 8'd0});
        ext_hot = 1'b1;
        #1;
        chk("R11 flag forces hot", {22'd0, sel_valid, sel_hot, sel_temp}, {22'd0, 1'b1, 1'b1, 8'd255});

        // only sideband enabled
        write_cfg(32'h0000_0286);
        capture();
        sb_temp = 8'd10;
        #1;
        chk("R10 estimate disabled", {22'd0, sel_valid, sel_hot, sel_temp}, {22'd0, 1'b1, 1'b0, 8'd10});

        // only estimate enabled
        write_cfg(32'h0000_0285);
        capture();
        ext_hot = 1'b0;
        sb_temp = 8'd200;
        #1;
        chk("R10 sideband disabled", 32'(sel_temp), 32'd40);

        // everything disabled
        write_cfg(32'h0000_0287);
        capture();
        ext_hot = 1'b1;
        #1;
        chk("R12 no source", {22'd0, sel_valid, sel_hot, sel_temp}, 32'd0);

        // all enabled with flag high
        write_cfg(32'h0000_0280);
        capture();
        chk("R11 flag overrides max", {23'd0, sel_hot, sel_temp}, {23'd0, 1'b1, 8'd255});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule